// File: doc/BRIEF.md
# Serial One-Time-Programmable Word Memory, Programming Mode

This block is a synthesizable behavioral model of a serially accessed one-time-programmable memory of 32-bit words, limited to its programming mode. A host enters the mode by walking an encoded supply-level input through a short clocked sequence while both control pins are high. In the mode, the two control pins choose one of three actions on each rising clock edge: shift a bit into the word register, shift a bit of the current word out, or step the word counter.

A word is committed by holding a write strobe for a set number of cycles. Because the storage is one-time, a write can only clear bits and never set them. A cascade output stays high until the final bit of the final word has been read. It then falls and stays low. Returning the supply level to its normal code leaves the mode and clears every counter, but the stored data is kept.

Top module: `otp_prog_model`

## Requirements
- R1: After reset every one of the DEPTH words (default 1134, each WORD_W = 32 bits) holds all ones. Reading a word that was never written returns all ones.
- R2: The supply-level code `vlevel` uses 00 = normal, 01 = level 1, 10 = level 2 and 11 = reserved. The mode is entered on the rising edge that sees code 10, provided the two edges just before it saw code 01. `ce` and `oe` must be high on all three edges. Any other value on any of these edges aborts the sequence, except that extra edges at code 01 keep it armed.
- R3: In the mode, an edge with `ce`=1 and `oe`=1 shifts `data_in` into the word register least-significant bit first. After WORD_W such edges, the first bit sits at bit 0.
- R4: In the mode, a cycle with `ce`=0 and `oe`=1 drives bit `b` of the current word on `data_out` and raises `data_oe`. Here `b` is the bit counter, which starts at 0, steps on each shift edge and wraps after WORD_W-1. `data_oe` is low in every other cycle.
- R5: In the mode, an edge with `ce`=1 and `oe`=0 steps the word counter. The counter stops at DEPTH, one past the last word. There, reads return 0 and writes are ignored.
- R6: Holding `pgm_strobe` high for STROBE_CYCLES consecutive edges in the mode performs exactly one write of the word register to the current word. A shorter pulse writes nothing.
- R7: A write stores the bitwise AND of the old word and the word register, so no stored 0 ever becomes 1.
- R8: `casc_out` is high until the rising edge that shifts out bit WORD_W-1 of word DEPTH-1. It is low from that edge onward and while the word counter is at DEPTH. It returns high one cycle after the mode is left.
- R9: An edge at code 00 while in the mode leaves the mode. The next edge clears the bit counter and the word counter. Stored words are unchanged.
- R10: Outside the mode, no combination of `ce`, `oe`, `data_in` and `pgm_strobe` changes any stored word, and `data_oe` stays low.
- R11: Code 11 does not count as level 1 or level 2 during entry. Inside the mode it neither exits nor disturbs the pin actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action occurs on its rising edge |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| ce | input | 1 | Chip-enable control pin |
| oe | input | 1 | Output-enable control pin |
| vlevel | input | 2 | Encoded supply level (00 normal, 01 level 1, 10 level 2, 11 reserved) |
| pgm_strobe | input | 1 | Write strobe; must be held STROBE_CYCLES edges |
| data_in | input | 1 | Serial data into the word register |
| data_out | output | 1 | Serial data out of the current word |
| data_oe | output | 1 | High while `data_out` is driven (shift-out cycles) |
| casc_out | output | 1 | Cascade flag; falls after the last bit of the array is read |

## Verification
Several properties hold on every cycle. The word counter never exceeds DEPTH. A rise into the mode is always preceded by a level-2 edge with both control pins high. The bit and word counters are zero one cycle after the mode is left. A write never turns a stored 0 into a 1, and a write is always preceded by a held strobe. Once the cascade flag is low, it stays low for as long as the mode lasts.

Some behaviour can only be shown by the bench scenarios with a small array. These are the least-significant-first order of the serial data, the exact cycle in which the cascade flag falls, the rejection of broken or reserved-code entry sequences, the rejection of short strobes, and the absence of any effect from pin activity outside the mode.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

   typedef enum logic [1:0] {
      LVL_NORM = 2'b00,
      LVL_ONE  = 2'b01,
      LVL_TWO  = 2'b10,
      LVL_RSVD = 2'b11
   } vlevel_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_ARM1,
      SEQ_ARM2,
      SEQ_PROG
   } seq_e;

   typedef struct packed {
      logic shift_in;
      logic shift_out;
      logic advance;
   } pin_op_s;

endpackage

// File: rtl/otp_entry_seq.sv
module otp_entry_seq
   import otp_prog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       oe,
   input  logic [1:0] vlevel,
   output logic       prog
);

   seq_e state_q;
   seq_e state_d;
   logic both_hi;

   assign both_hi = ce & oe;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: state_d = (both_hi && vlevel == LVL_ONE) ? SEQ_ARM1 : SEQ_IDLE;
         SEQ_ARM1: state_d = (both_hi && vlevel == LVL_ONE) ? SEQ_ARM2 : SEQ_IDLE;
         SEQ_ARM2: begin
            if (both_hi && vlevel == LVL_TWO)      state_d = SEQ_PROG;
            else if (both_hi && vlevel == LVL_ONE) state_d = SEQ_ARM2;
            else                                   state_d = SEQ_IDLE;
         end
         SEQ_PROG: state_d = (vlevel == LVL_NORM) ? SEQ_IDLE : SEQ_PROG;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign prog = (state_q == SEQ_PROG);

   assert_entry_needs_l2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog) |-> ($past(vlevel) == LVL_TWO && $past(ce) && $past(oe)));

   assert_exit_on_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && vlevel == LVL_NORM) |=> !prog);

   assert_rsvd_holds_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && vlevel == LVL_RSVD) |=> prog);

endmodule

// File: rtl/otp_word_shifter.sv
module otp_word_shifter #(
   parameter int WORD_W = 32,
   parameter int BIT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              shift_in,
   input  logic              shift_out,
   input  logic              data_in,
   output logic [WORD_W-1:0] word_q,
   output logic [BIT_W-1:0]  bitidx,
   output logic              last_bit
);

   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_W - 1);

   assign last_bit = (bitidx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         bitidx <= '0;
      end else if (!prog) begin
         word_q <= '0;
         bitidx <= '0;
      end else begin
         if (shift_in)
            word_q <= {data_in, word_q[WORD_W-1:1]};
         if (shift_in || shift_out)
            bitidx <= last_bit ? '0 : bitidx + 1'b1;
      end
   end

   assert_lsb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && shift_in) |=> (word_q[WORD_W-1] == $past(data_in)));

   assert_bit_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && shift_out && last_bit) |=> (bitidx == '0));

endmodule

// File: rtl/otp_word_counter.sv
module otp_word_counter #(
   parameter int DEPTH  = 1134,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              advance,
   input  logic              shift_out,
   input  logic              last_bit,
   output logic [ADDR_W-1:0] addr,
   output logic              past_end,
   output logic              casc_out
);

   localparam logic [ADDR_W-1:0] END_ADDR  = ADDR_W'(DEPTH);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic read_done;

   assign past_end = (addr == END_ADDR);
   assign casc_out = ~(read_done | past_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr      <= '0;
         read_done <= 1'b0;
      end else if (!prog) begin
         addr      <= '0;
         read_done <= 1'b0;
      end else begin
         if (advance && !past_end)
            addr <= addr + 1'b1;
         if (shift_out && last_bit && addr == LAST_ADDR)
            read_done <= 1'b1;
      end
   end

   assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= END_ADDR);

   assert_casc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && !casc_out) |=> (!casc_out || !prog));

endmodule

// File: rtl/otp_array.sv
module otp_array #(
   parameter int WORD_W        = 32,
   parameter int DEPTH         = 1134,
   parameter int STROBE_CYCLES = 4,
   parameter int ADDR_W        = 11,
   parameter int IDX_W         = 11,
   parameter int BIT_W         = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic [ADDR_W-1:0] addr,
   input  logic              past_end,
   input  logic              pgm_strobe,
   input  logic [WORD_W-1:0] wdata,
   input  logic [BIT_W-1:0]  rd_sel,
   output logic              rd_bit
);

   localparam int SC_W = $clog2(STROBE_CYCLES + 1);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] rd_word;
   logic              fire;
   logic              wr_en;

   assign idx = addr[IDX_W-1:0];

   generate
      if (STROBE_CYCLES == 1) begin : g_edge
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= prog & pgm_strobe;
         end
         assign fire = prog & pgm_strobe & ~strobe_q;
      end else begin : g_timer
         logic [SC_W-1:0] scnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    scnt <= '0;
            else if (!(prog && pgm_strobe)) scnt <= '0;
            else if (scnt != SC_W'(STROBE_CYCLES)) scnt <= scnt + 1'b1;
         end
         assign fire = prog & pgm_strobe & (scnt == SC_W'(STROBE_CYCLES - 1));

         assert_strobe_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            fire |-> $past(pgm_strobe));
      end
   endgenerate

   assign wr_en = fire & ~past_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_en) begin
         mem[idx] <= mem[idx] & wdata;
      end
   end

   assign rd_word = past_end ? '0 : mem[idx];
   assign rd_bit  = rd_word[rd_sel];

   logic [WORD_W-1:0] chk_old;
   logic [IDX_W-1:0]  chk_idx;
   logic              chk_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_v   <= 1'b0;
         chk_old <= '0;
         chk_idx <= '0;
      end else begin
         chk_v   <= wr_en;
         chk_old <= rd_word;
         chk_idx <= idx;
      end
   end

   assert_otp_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_v |-> ((mem[chk_idx] & ~chk_old) == '0));

endmodule

// File: rtl/otp_prog_model.sv
module otp_prog_model
   import otp_prog_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int DEPTH         = 1134,
   parameter int STROBE_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       oe,
   input  logic [1:0] vlevel,
   input  logic       pgm_strobe,
   input  logic       data_in,
   output logic       data_out,
   output logic       data_oe,
   output logic       casc_out
);

   localparam int BIT_W  = $clog2(WORD_W);
   localparam int ADDR_W = $clog2(DEPTH + 1);
   localparam int IDX_W  = $clog2(DEPTH);

   initial begin
      if (WORD_W < 2)        $fatal(1, "WORD_W must be at least 2");
      if (DEPTH < 2)         $fatal(1, "DEPTH must be at least 2");
      if (STROBE_CYCLES < 1) $fatal(1, "STROBE_CYCLES must be at least 1");
   end

   logic              prog;
   pin_op_s           op;
   logic [WORD_W-1:0] word_q;
   logic [BIT_W-1:0]  bitidx;
   logic              last_bit;
   logic [ADDR_W-1:0] addr;
   logic              past_end;
   logic              rd_bit;

   assign op.shift_in  = prog &  ce &  oe;
   assign op.shift_out = prog & ~ce &  oe;
   assign op.advance   = prog &  ce & ~oe;

   otp_entry_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (ce),
      .oe     (oe),
      .vlevel (vlevel),
      .prog   (prog)
   );

   otp_word_shifter #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (prog),
      .shift_in  (op.shift_in),
      .shift_out (op.shift_out),
      .data_in   (data_in),
      .word_q    (word_q),
      .bitidx    (bitidx),
      .last_bit  (last_bit)
   );

   otp_word_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wcnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (prog),
      .advance   (op.advance),
      .shift_out (op.shift_out),
      .last_bit  (last_bit),
      .addr      (addr),
      .past_end  (past_end),
      .casc_out  (casc_out)
   );

   otp_array #(
      .WORD_W        (WORD_W),
      .DEPTH         (DEPTH),
      .STROBE_CYCLES (STROBE_CYCLES),
      .ADDR_W        (ADDR_W),
      .IDX_W         (IDX_W),
      .BIT_W         (BIT_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog       (prog),
      .addr       (addr),
      .past_end   (past_end),
      .pgm_strobe (pgm_strobe),
      .wdata      (word_q),
      .rd_sel     (bitidx),
      .rd_bit     (rd_bit)
   );

   assign data_oe  = op.shift_out;
   assign data_out = op.shift_out & rd_bit;

   assert_exit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog) |=> (bitidx == '0 && addr == '0));

   assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog && !$past(prog)) |-> (casc_out && !data_oe));

endmodule

// File: tb/otp_prog_model_bench.sv
`timescale 1ns/1ps
module otp_prog_model_bench;

   localparam int W  = 32;
   localparam int D  = 6;
   localparam int SC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b0, oe = 1'b0, pgm_strobe = 1'b0, data_in = 1'b0;
   logic [1:0] vlevel = 2'b00;
   logic       data_out, data_oe, casc_out;

   int total = 0;
   int bad   = 0;
   logic [W-1:0] exp_mem [D];

   always #4 clk = ~clk;

   otp_prog_model #(.WORD_W(W), .DEPTH(D), .STROBE_CYCLES(SC)) u_otp_prog_model (
      .clk(clk), .rst_n(rst_n), .ce(ce), .oe(oe), .vlevel(vlevel),
      .pgm_strobe(pgm_strobe), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .casc_out(casc_out)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic o, input logic [1:0] lv, input logic st, input logic d);
      @(negedge clk);
      ce = c; oe = o; vlevel = lv; pgm_strobe = st; data_in = d;
      @(posedge clk);
   endtask

   task automatic enter();
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b10, 0, 0);
   endtask

   task automatic leave();
      step(0, 0, 2'b00, 0, 0);
      step(0, 0, 2'b00, 0, 0);
   endtask

   task automatic shift_word(input logic [W-1:0] v, input logic [1:0] lv);
      for (int i = 0; i < W; i++) step(1, 1, lv, 0, v[i]);
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 2'b10, 1, 0);
      step(0, 0, 2'b10, 0, 0);
   endtask

   task automatic advance();
      step(1, 0, 2'b10, 0, 0);
   endtask

   task automatic read_word(input string req, input logic [W-1:0] exp, input logic [1:0] lv);
      logic [W-1:0] got;
      logic oe_ok;
      got = '0;
      oe_ok = 1'b1;
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         ce = 0; oe = 1; vlevel = lv; pgm_strobe = 0; data_in = 0;
         #1;
         got[i] = data_out;
         if (data_oe !== 1'b1) oe_ok = 1'b0;
         @(posedge clk);
      end
      chk(oe_ok, "R4 data_oe during shift-out", {31'd0, oe_ok}, 32'd1);
      chk(got === exp, req, got, exp);
   endtask

   task automatic probe_oe(input string req, input logic expv);
      @(negedge clk);
      ce = 0; oe = 1; vlevel = 2'b10; pgm_strobe = 0; data_in = 0;
      #1;
      chk(data_oe === expv, req, {31'd0, data_oe}, {31'd0, expv});
      @(posedge clk);
   endtask

   function automatic logic [W-1:0] pat(input int w);
      return 32'hA5C3_0F96 ^ (32'(w) * 32'h1357_9BDF) ^ (32'h8000_0001 << w);
   endfunction

   initial begin
      #(8 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired (all requirements)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] p0, q0;
      for (int w = 0; w < D; w++) exp_mem[w] = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(casc_out === 1'b1, "R8 reset casc high", {31'd0, casc_out}, 32'd1);
      chk(data_oe === 1'b0, "R10 reset data_oe low", {31'd0, data_oe}, 32'd0);

      // R10: outside the mode, pin activity does nothing
      probe_oe("R10 no data_oe outside mode", 1'b0);
      shift_word(32'h0000_0000, 2'b10);
      strobe(SC + 1);
      advance();

      // R1 / R4 / R2: enter and read erased word 0
      enter();
      read_word("R1 erased word 0", 32'hFFFF_FFFF, 2'b10);

      // R3 / R6: write pattern to word 0
      p0 = 32'h1234_5678;
      shift_word(p0, 2'b10);
      strobe(SC);
      exp_mem[0] = exp_mem[0] & p0;
      read_word("R3 R6 word 0 after write", exp_mem[0], 2'b10);

      // R6: short strobe writes nothing
      q0 = 32'h0F0F_00FF;
      shift_word(q0, 2'b10);
      strobe(SC - 1);
      read_word("R6 short strobe ignored", exp_mem[0], 2'b10);

      // R7: second write ANDs
      shift_word(q0, 2'b10);
      strobe(SC);
      exp_mem[0] = exp_mem[0] & q0;
      read_word("R7 AND on rewrite", exp_mem[0], 2'b10);
      chk(exp_mem[0] === (p0 & q0), "R7 bench model", exp_mem[0], p0 & q0);

      // R5: walk words 1..D-1
      for (int w = 1; w < D; w++) begin
         advance();
         if (w < D - 1) begin
            read_word("R1 erased word", 32'hFFFF_FFFF, 2'b10);
            shift_word(pat(w), 2'b10);
            strobe(SC);
            exp_mem[w] = exp_mem[w] & pat(w);
            read_word("R5 word after advance", exp_mem[w], 2'b10);
         end
      end

      // R8: last word, cascade timing
      shift_word(pat(D - 1), 2'b10);
      strobe(SC);
      exp_mem[D - 1] = exp_mem[D - 1] & pat(D - 1);
      begin
         logic [W-1:0] got;
         got = '0;
         for (int i = 0; i < W; i++) begin
            @(negedge clk);
            ce = 0; oe = 1; vlevel = 2'b10; pgm_strobe = 0; data_in = 0;
            #1;
            got[i] = data_out;
            if (i == W - 1)
               chk(casc_out === 1'b1, "R8 casc high before last bit edge", {31'd0, casc_out}, 32'd1);
            @(posedge clk);
         end
         chk(got === exp_mem[D - 1], "R5 last word content", got, exp_mem[D - 1]);
         @(negedge clk);
         ce = 0; oe = 0;
         #1;
         chk(casc_out === 1'b0, "R8 casc low after last bit", {31'd0, casc_out}, 32'd0);
      end

      // R5: past the end reads zero, writes ignored, saturates
      advance();
      read_word("R5 past-end reads zero", 32'h0000_0000, 2'b10);
      shift_word(32'h0000_0000, 2'b10);
      strobe(SC);
      advance();
      advance();
      read_word("R5 saturated counter reads zero", 32'h0000_0000, 2'b10);
      #1;
      chk(casc_out === 1'b0, "R8 casc low past end", {31'd0, casc_out}, 32'd0);

      // R9: exit clears counters, casc returns high
      leave();
      #1;
      chk(casc_out === 1'b1, "R9 R8 casc high after exit", {31'd0, casc_out}, 32'd1);
      probe_oe("R9 no data_oe after exit", 1'b0);

      // R2: broken entry sequences
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b10, 0, 0);
      probe_oe("R2 single level-1 edge rejected", 1'b0);
      step(1, 1, 2'b01, 0, 0);
      step(0, 1, 2'b01, 0, 0);
      step(1, 1, 2'b10, 0, 0);
      probe_oe("R2 ce low during entry rejected", 1'b0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b11, 0, 0);
      step(1, 1, 2'b10, 0, 0);
      probe_oe("R11 reserved code breaks entry", 1'b0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b01, 0, 0);
      step(1, 1, 2'b10, 0, 0);
      read_word("R2 extra level-1 edge still enters; word 0", exp_mem[0], 2'b10);

      // R9: partial shift and advance, then exit and re-enter
      for (int i = 0; i < 5; i++) step(1, 1, 2'b10, 0, 1);
      advance();
      advance();
      leave();
      enter();
      read_word("R9 counters cleared on exit", exp_mem[0], 2'b10);

      // R11: reserved code inside the mode keeps it
      advance();
      read_word("R11 reserved code in mode", exp_mem[1], 2'b11);
      leave();

      // R10 / R5: every word intact after out-of-mode and past-end activity
      shift_word(32'h0000_0000, 2'b10);
      strobe(SC + 2);
      enter();
      for (int w = 0; w < D; w++) begin
         read_word("R10 R5 final content", exp_mem[w], 2'b10);
         advance();
      end
      leave();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule